// File: doc/BRIEF.md
# Coin-Accumulating Dispenser Controller

This block controls a single-slot coin acceptor that releases one item once the inserted credit reaches at least 15 cents. Two sensor inputs report coins: one pulses for a 5-cent piece and the other for a 10-cent piece. Each coin is reported as a pulse lasting one clock cycle. The block keeps the running credit in a two-bit state register. It drives a single release line that depends on that state alone.

Overpayment is absorbed without any change being returned. Once credit reaches the 15-or-more level, the machine stays there until a synchronous reset clears it. A cycle in which both sensors report a coin at once is treated as a sensor fault and is ignored.

Top module: `coin_dispenser_ctrl`

## Requirements
- R1: With `rst` high at a rising edge, credit goes to the zero level (state code 00), and `release_o` is low in the following cycle.
- R2: A cycle with only `coin_nickel` high adds five cents. The credit moves 00 to 01, 01 to 10, and 10 to 11 (15-or-more).
- R3: A cycle with only `coin_dime` high adds ten cents. The credit moves 00 to 10, and moves from either 01 or 10 to 11, discarding any excess.
- R4: A cycle with both coin inputs low leaves the credit unchanged.
- R5: A cycle with both coin inputs high is ignored, and the credit is unchanged.
- R6: The 15-or-more level (code 11) is absorbing: coin inputs of any kind leave it there, and only reset leaves it.
- R7: `release_o` is high exactly while the credit is at code 11. It rises in the cycle after the edge that completed the price.
- R8: Reset applied while at the 15-or-more level returns the machine to zero credit, and normal counting then resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_nickel | input | 1 | One-cycle pulse per 5-cent coin |
| coin_dime | input | 1 | One-cycle pulse per 10-cent coin |
| release_o | output | 1 | Item release, high while credit is 15 cents or more |

## Verification
The top module has no tunable sizes, so the bench builds it in its only configuration, which has four credit levels and two coin channels. This small state space lets the bench drive all four input combinations from each credit level, including the faulty both-coins case. It also follows each of those cycles with further coins, so that an ignored input shows up later as a release that does or does not happen. A behavioural credit counter in cents, saturating at 15, predicts the release line on every cycle.

// File: rtl/coin_credit_pkg.sv
package coin_credit_pkg;

  localparam int NUM_LEVELS = 4;
  localparam int CREDIT_W   = $clog2(NUM_LEVELS);

  // Credit levels; the code values follow the credit in 5-cent steps.
  typedef enum logic [CREDIT_W-1:0] {
    CR_ZERO = 2'b00,
    CR_FIVE = 2'b01,
    CR_TEN  = 2'b10,
    CR_FULL = 2'b11
  } credit_t;

  // Classified sensor event for one cycle.
  typedef enum logic [1:0] {
    EV_NONE  = 2'b00,
    EV_FIVE  = 2'b01,
    EV_TEN   = 2'b10,
    EV_FAULT = 2'b11
  } coin_ev_t;

endpackage

// File: rtl/coin_classify.sv
module coin_classify
  import coin_credit_pkg::*;
(
  input  logic     nickel_i,
  input  logic     dime_i,
  output coin_ev_t event_o
);

  always_comb begin
    unique case ({dime_i, nickel_i})
      2'b01:   event_o = EV_FIVE;
      2'b10:   event_o = EV_TEN;
      2'b11:   event_o = EV_FAULT;
      default: event_o = EV_NONE;
    endcase
  end

endmodule

// File: rtl/credit_step.sv
module credit_step
  import coin_credit_pkg::*;
(
  input  credit_t  cur_i,
  input  coin_ev_t event_i,
  output credit_t  nxt_o
);

  always_comb begin
    nxt_o = cur_i;
    if (cur_i != CR_FULL) begin
      unique case (event_i)
        EV_FIVE: begin
          unique case (cur_i)
            CR_ZERO: nxt_o = CR_FIVE;
            CR_FIVE: nxt_o = CR_TEN;
            default: nxt_o = CR_FULL;
          endcase
        end
        EV_TEN: begin
          if (cur_i == CR_ZERO) nxt_o = CR_TEN;
          else                  nxt_o = CR_FULL;
        end
        default: nxt_o = cur_i;
      endcase
    end
  end

endmodule

// File: rtl/credit_reg.sv
module credit_reg
  import coin_credit_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  credit_t d_i,
  output credit_t q_o
);

  always_ff @(posedge clk) begin
    if (rst) q_o <= CR_ZERO;
    else     q_o <= d_i;
  end

endmodule

// File: rtl/coin_dispenser_ctrl.sv
module coin_dispenser_ctrl
  import coin_credit_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic coin_nickel,
  input  logic coin_dime,
  output logic release_o
);

  coin_ev_t coin_ev;
  credit_t  credit_d;
  credit_t  credit_q;

  coin_classify u_classify (
    .nickel_i (coin_nickel),
    .dime_i   (coin_dime),
    .event_o  (coin_ev)
  );

  credit_step u_step (
    .cur_i   (credit_q),
    .event_i (coin_ev),
    .nxt_o   (credit_d)
  );

  credit_reg u_reg (
    .clk (clk),
    .rst (rst),
    .d_i (credit_d),
    .q_o (credit_q)
  );

  // Moore output: a function of the registered credit only.
  assign release_o = (credit_q == CR_FULL);

endmodule

// File: rtl/coin_dispenser_chk.sv
module coin_dispenser_chk
  import coin_credit_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    coin_nickel,
  input logic    coin_dime,
  input logic    release_o,
  input credit_t credit_q
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!release_o && credit_q == CR_ZERO));

  assert_nickel_from_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (credit_q == CR_ZERO && coin_nickel && !coin_dime) |=> (credit_q == CR_FIVE));

  assert_nickel_completes_R2: assert property (@(posedge clk) disable iff (rst)
    (credit_q == CR_TEN && coin_nickel && !coin_dime) |=> release_o);

  assert_dime_from_five_R3: assert property (@(posedge clk) disable iff (rst)
    (credit_q == CR_FIVE && coin_dime && !coin_nickel) |=> release_o);

  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!coin_nickel && !coin_dime) |=> $stable(credit_q));

  assert_fault_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (coin_nickel && coin_dime) |=> $stable(credit_q));

  assert_full_absorbs_R6: assert property (@(posedge clk) disable iff (rst)
    release_o |=> release_o);

  assert_release_needs_coin_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(release_o) |-> ($past(coin_nickel) != $past(coin_dime)));

endmodule

bind coin_dispenser_ctrl coin_dispenser_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .coin_nickel (coin_nickel),
  .coin_dime   (coin_dime),
  .release_o   (release_o),
  .credit_q    (credit_q)
);

// File: tb/tb_coin_dispenser_ctrl.sv
`timescale 1ns/1ps
module tb_coin_dispenser_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin_nickel = 1'b0;
  logic coin_dime = 1'b0;
  logic release_o;

  int vectors = 0;
  int miscompares = 0;
  int model_cents = 0;

  always #10 clk = ~clk;

  coin_dispenser_ctrl dut (
    .clk         (clk),
    .rst         (rst),
    .coin_nickel (coin_nickel),
    .coin_dime   (coin_dime),
    .release_o   (release_o)
  );

  // Drive one cycle, advance the cents model, compare after the edge.
  task automatic step(input logic r, input logic n, input logic d, input string tag);
    logic exp;
    @(negedge clk);
    rst = r; coin_nickel = n; coin_dime = d;
    @(posedge clk);
    if (r) model_cents = 0;
    else if (model_cents >= 15) model_cents = model_cents;
    else if (n && d) model_cents = model_cents;
    else if (n) model_cents = model_cents + 5;
    else if (d) model_cents = model_cents + 10;
    if (model_cents > 15) model_cents = 15;
    @(negedge clk);
    exp = (model_cents >= 15);
    vectors++;
    if (release_o !== exp) begin
      miscompares++;
      $display("FAIL %s: release_o=%b expected=%b (credit %0d cents)", tag, release_o, exp, model_cents);
    end
    rst = 1'b0; coin_nickel = 1'b0; coin_dime = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    step(1, 0, 0, "R1");
    step(1, 1, 1, "R1");
    step(0, 0, 0, "R1");

    // R2, R7: three nickels, release rises after the third
    step(0, 1, 0, "R2");
    step(0, 1, 0, "R2");
    step(0, 0, 0, "R4");
    step(0, 1, 0, "R7");
    step(0, 0, 0, "R7");

    // R8: reset out of the full level, then counting resumes
    step(1, 0, 0, "R8");
    step(0, 1, 0, "R8");
    step(0, 0, 1, "R8");

    // R3: dime paths and overpayment
    step(1, 0, 0, "R1");
    step(0, 0, 1, "R3");
    step(0, 0, 0, "R4");
    step(0, 0, 0, "R4");
    step(0, 0, 1, "R3");
    step(1, 0, 0, "R1");
    step(0, 1, 0, "R2");
    step(0, 0, 1, "R3");

    // R6: full level ignores every input combination
    step(0, 1, 0, "R6");
    step(0, 0, 1, "R6");
    step(0, 1, 1, "R6");
    step(0, 0, 0, "R6");

    // R5: fault cycles at each non-full level leave credit alone
    step(1, 0, 0, "R1");
    step(0, 1, 1, "R5");
    step(0, 1, 0, "R5");
    step(0, 1, 1, "R5");
    step(0, 1, 0, "R5");
    step(0, 1, 1, "R5");
    step(0, 1, 1, "R5");
    step(0, 1, 0, "R5");

    // Exhaustive: every input pattern from every non-full level,
    // followed by nickels that expose the resulting credit.
    for (int lvl = 0; lvl < 3; lvl++) begin
      for (int pat = 0; pat < 4; pat++) begin
        step(1, 0, 0, "R1");
        for (int k = 0; k < lvl; k++) step(0, 1, 0, "R2");
        step(0, pat[0], pat[1],
             (pat == 3) ? "R5" : (pat == 2) ? "R3" : (pat == 1) ? "R2" : "R4");
        step(0, 1, 0, "R7");
        step(0, 1, 0, "R7");
        step(0, 1, 0, "R6");
      end
    end

    finish_run();
  end

endmodule